// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register mailbox that lets a host processor hand commands to an embedded power-management controller. The host writes a data word and a command word, whose byte lanes hold an opcode, a controller (pipe) index and a one-byte parameter. It then rings a doorbell bit in a control register. While the doorbell is up, the controller side sees a valid command with its fields already split out. It acknowledges with a one-cycle pulse, which drops the doorbell and tells the host that the next command may be posted.

The host side is a simple single-cycle register bus with per-byte write enables and a combinational read path. The consumer side is a valid/ack pair. While a command is pending, the command and data words are frozen: any host write to either is discarded and latches a sticky error flag. Two command forms get special treatment on the consumer side. A level-set command whose parameter is the reserved value 255 raises an immediate-disable strobe. A set-backlight command addressed to controller index 0 presents a zero ramp value, whatever the host stored.

Top module: `mbox_cmd_mailbox`

## Requirements
- R1: After reset the command word, data word, doorbell and error flag all read 0, and cmd_valid and cmd_kill are low.
- R2: Register map: address 0 is the command word, address 1 the data word, address 2 the control register (bit 0 doorbell, bit 1 error), and address 3 reads 0. A write to address 0 or 1 while the doorbell is clear updates only the bytes whose reg_be bit is 1, and the new value reads back from the next cycle.
- R3: A write to address 2 with reg_be[0]=1 and reg_wdata[0]=1 sets the doorbell on that clock. A host write of 0 to bit 0 never clears it.
- R4: While the doorbell is set, host writes to the command or data word leave the stored value unchanged.
- R5: cmd_ack while cmd_valid is high clears the doorbell on that clock edge. cmd_ack while cmd_valid is low has no effect.
- R6: A host write to address 0 or 1 while the doorbell is set sets the error flag (control bit 1 and err_flag). The flag stays set until reset.
- R7: cmd_valid equals the doorbell. While it is high, cmd_opcode shows command bits [7:0], cmd_index shows bits [15:8] and cmd_param shows bits [23:16].
- R8: cmd_kill is high exactly when cmd_valid is high, the opcode is 0x65 (level set) and the parameter is 0xFF. Opcodes 0x66 (pipe select) and 0x67 (set backlight) never raise it.
- R9: When the pending opcode is 0x67 and cmd_index is 0, cmd_data reads 0. In every other case cmd_data is the stored data word. The data register read back over the host bus keeps the written value in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe, one cycle per write |
| reg_addr | input | 2 | Host register address |
| reg_be | input | 4 | Host byte write enables |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr (combinational) |
| cmd_valid | output | 1 | A command is pending (doorbell set) |
| cmd_opcode | output | 8 | Pending opcode |
| cmd_index | output | 8 | Pending controller index |
| cmd_param | output | 8 | Pending parameter byte |
| cmd_data | output | 32 | Pending data word (zeroed for backlight to index 0) |
| cmd_kill | output | 1 | Immediate-disable request is pending |
| cmd_ack | input | 1 | Consumer has taken the command |
| err_flag | output | 1 | Sticky flag: a write hit the locked words |

## Verification
The hardest situation to reach is a host write that lands while a command is still pending. A well-behaved host polls the doorbell first, and a prompt consumer clears it within a cycle, so the locked window hardly ever lasts long enough to hit. The bench therefore parks its consumer monitor: the doorbell stays up while the driver writes to the command and data words, reads them back unchanged, and sees the error bit appear. Only after that does it release the monitor, which then pops the expected item. A stray acknowledge sent while nothing is pending is also driven on purpose, to show that it changes nothing.

// File: rtl/mbox_pkg.sv
// Package: shared constants and the register address type for the
// command mailbox. Assumes a word of at least three byte lanes.
package mbox_pkg;

    localparam int unsigned LANE_W     = 8;
    localparam int unsigned LANE_OP    = 0;   // opcode byte lane
    localparam int unsigned LANE_IDX   = 1;   // controller index byte lane
    localparam int unsigned LANE_PARAM = 2;   // parameter byte lane

    localparam logic [7:0] OP_LEVEL  = 8'h65;
    localparam logic [7:0] OP_PIPE   = 8'h66;
    localparam logic [7:0] OP_BLIGHT = 8'h67;
    localparam logic [7:0] PARAM_KILL = 8'hFF;

    typedef enum logic [1:0] {
        A_CMD  = 2'd0,
        A_DATA = 2'd1,
        A_CTRL = 2'd2,
        A_RSVD = 2'd3
    } mbox_addr_e;

endpackage

// File: rtl/mbox_host_regs.sv
// Module: host-side register file of the mailbox. Holds the command
// word, the data word, the doorbell and the sticky error flag.
// Assumes single-cycle writes with byte enables and a combinational
// read. The doorbell is set only by the host and cleared only by ack.
module mbox_host_regs
    import mbox_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned NLANE = WORD_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [NLANE-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ack,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] data_q,
    output logic              db_q,
    output logic              err_q
);

    logic wr_cmd, wr_data, wr_ctrl, ring;

    // Decode the host write target and the doorbell request.
    always_comb begin
        wr_cmd  = wr && (addr == A_CMD);
        wr_data = wr && (addr == A_DATA);
        wr_ctrl = wr && (addr == A_CTRL);
        ring    = wr_ctrl && be[0] && wdata[0];
    end

    // One storage lane per byte, written only while the mailbox is open.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_q[g*LANE_W +: LANE_W]  <= '0;
                data_q[g*LANE_W +: LANE_W] <= '0;
            end else if (!db_q && be[g]) begin
                if (wr_cmd)
                    cmd_q[g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
                if (wr_data)
                    data_q[g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
            end
        end
    end

    // Doorbell: host sets, consumer ack clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            db_q <= 1'b0;
        else if (db_q && ack)
            db_q <= 1'b0;
        else if (ring)
            db_q <= 1'b1;
    end

    // Sticky error on a write that hits the locked words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (db_q && (wr_cmd || wr_data))
            err_q <= 1'b1;
    end

    // Host read multiplexer.
    always_comb begin
        unique case (mbox_addr_e'(addr))
            A_CMD:   rdata = cmd_q;
            A_DATA:  rdata = data_q;
            A_CTRL:  rdata = {{(WORD_W-2){1'b0}}, err_q, db_q};
            default: rdata = '0;
        endcase
    end

    p_db_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_q && ring) |=> db_q);
    p_db_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (db_q && !ack) |=> db_q);
    p_cmd_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        db_q |=> $stable(cmd_q));
    p_data_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        db_q |=> $stable(data_q));
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (db_q && ack) |=> !db_q);
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_err_on_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (db_q && wr && (addr == A_CMD || addr == A_DATA)) |=> err_q);

endmodule

// File: rtl/mbox_cmd_view.sv
// Module: consumer-side view of the pending command. Splits the byte
// lanes, flags the immediate-disable request and zeroes the ramp for a
// backlight command sent to controller index 0. Purely combinational.
module mbox_cmd_view
    import mbox_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              pending,
    input  logic [7:0]        op_in,
    input  logic [7:0]        idx_in,
    input  logic [7:0]        param_in,
    input  logic [WORD_W-1:0] data_in,
    output logic              valid,
    output logic [7:0]        opcode,
    output logic [7:0]        index,
    output logic [7:0]        param,
    output logic [WORD_W-1:0] data,
    output logic              kill
);

    // Present fields and derive the special cases.
    always_comb begin
        valid  = pending;
        opcode = op_in;
        index  = idx_in;
        param  = param_in;
        kill   = pending && (op_in == OP_LEVEL) && (param_in == PARAM_KILL);
        if ((op_in == OP_BLIGHT) && (idx_in == 8'd0))
            data = '0;
        else
            data = data_in;
    end

endmodule

// File: rtl/mbox_cmd_mailbox.sv
// Module: top of the host-to-controller command mailbox. Joins the
// host register file to the consumer view. Assumes WORD_W is a
// multiple of 8 and at least 24 so the three command lanes exist.
module mbox_cmd_mailbox
    import mbox_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned NLANE = WORD_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [NLANE-1:0]  reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              cmd_valid,
    output logic [7:0]        cmd_opcode,
    output logic [7:0]        cmd_index,
    output logic [7:0]        cmd_param,
    output logic [WORD_W-1:0] cmd_data,
    output logic              cmd_kill,
    input  logic              cmd_ack,
    output logic              err_flag
);

    logic [WORD_W-1:0] cmd_q, data_q;
    logic              db_q, err_q;

    mbox_host_regs #(.WORD_W(WORD_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .be     (reg_be),
        .wdata  (reg_wdata),
        .ack    (cmd_ack),
        .rdata  (reg_rdata),
        .cmd_q  (cmd_q),
        .data_q (data_q),
        .db_q   (db_q),
        .err_q  (err_q)
    );

    mbox_cmd_view #(.WORD_W(WORD_W)) u_view (
        .pending  (db_q),
        .op_in    (cmd_q[LANE_OP*LANE_W +: 8]),
        .idx_in   (cmd_q[LANE_IDX*LANE_W +: 8]),
        .param_in (cmd_q[LANE_PARAM*LANE_W +: 8]),
        .data_in  (data_q),
        .valid    (cmd_valid),
        .opcode   (cmd_opcode),
        .index    (cmd_index),
        .param    (cmd_param),
        .data     (cmd_data),
        .kill     (cmd_kill)
    );

    // Expose the sticky error flag.
    always_comb err_flag = err_q;

    p_kill_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_kill |-> (cmd_valid && cmd_opcode == OP_LEVEL));
    p_ramp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_BLIGHT && cmd_index == 8'd0) |-> (cmd_data == '0));
    p_view_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_param)));

endmodule

// File: tb/tb_mbox_cmd_mailbox.sv
// Scoreboard bench: the driver posts commands and queues the expected
// consumer view; the monitor pops and compares when cmd_valid shows up.
module tb_mbox_cmd_mailbox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [3:0]  reg_be = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        cmd_valid, cmd_kill, cmd_ack = 1'b0, err_flag;
    logic [7:0]  cmd_opcode, cmd_index, cmd_param;
    logic [31:0] cmd_data;

    int n_chk = 0;
    int n_err = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0]  op;
        logic [7:0]  idx;
        logic [7:0]  prm;
        logic [31:0] dat;
        logic        kill;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    mbox_cmd_mailbox dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_index(cmd_index),
        .cmd_param(cmd_param), .cmd_data(cmd_data), .cmd_kill(cmd_kill),
        .cmd_ack(cmd_ack), .err_flag(err_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = b;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Driver: post one command and queue its expected consumer view.
    task automatic post(input logic [7:0] op, input logic [7:0] idx,
                        input logic [7:0] prm, input logic [31:0] dat);
        item_t it;
        logic [31:0] v;
        it.op = op; it.idx = idx; it.prm = prm;
        it.dat  = (op == 8'h67 && idx == 8'd0) ? 32'd0 : dat;
        it.kill = (op == 8'h65 && prm == 8'hFF);
        exp_q.push_back(it);
        wr(2'd1, dat, 4'hF);
        wr(2'd0, {8'h00, prm, idx, op}, 4'hF);
        wr(2'd2, 32'd1, 4'h1);
        for (int i = 0; i < 50; i++) begin
            rd(2'd2, v);
            if (v[0] == 1'b0) break;
        end
        check("R5 doorbell released after post", {31'd0, v[0]}, 32'd0);
    endtask

    // Monitor: compare each pending command with the scoreboard, then ack.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && cmd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected command", 32'd1, 32'd0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check("R7 opcode", {24'd0, cmd_opcode}, {24'd0, e.op});
                    check("R7 index", {24'd0, cmd_index}, {24'd0, e.idx});
                    check("R7 param", {24'd0, cmd_param}, {24'd0, e.prm});
                    check("R9 data", cmd_data, e.dat);
                    check("R8 kill", {31'd0, cmd_kill}, {31'd0, e.kill});
                end
                cmd_ack = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0;
                check("R5 valid drops after ack", {31'd0, cmd_valid}, 32'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); check("R1 cmd reset", v, 32'd0);
        rd(2'd1, v); check("R1 data reset", v, 32'd0);
        rd(2'd2, v); check("R1 ctrl reset", v, 32'd0);
        check("R1 valid low", {31'd0, cmd_valid}, 32'd0);
        check("R1 kill low", {31'd0, cmd_kill}, 32'd0);
        // R2 byte-enabled writes and map
        wr(2'd0, 32'hAABBCCDD, 4'hF);
        wr(2'd0, 32'h11223344, 4'b0010);
        rd(2'd0, v); check("R2 cmd byte enables", v, 32'hAABB33DD);
        wr(2'd1, 32'h12345678, 4'b1001);
        rd(2'd1, v); check("R2 data byte enables", v, 32'h12000078);
        rd(2'd3, v); check("R2 reserved address", v, 32'd0);
        // R3 writing zero does not ring
        wr(2'd2, 32'd0, 4'h1);
        rd(2'd2, v); check("R3 zero write no ring", v, 32'd0);
        // Scoreboard traffic
        mon_en = 1'b1;
        post(8'h66, 8'd2, 8'h00, 32'h0000FFFF);
        post(8'h65, 8'd0, 8'h40, 32'h00000000);
        post(8'h65, 8'd0, 8'hFF, 32'h00000000);
        post(8'h67, 8'd0, 8'h00, 32'h0000FFFF);
        rd(2'd1, v); check("R9 data register keeps value", v, 32'h0000FFFF);
        post(8'h67, 8'd1, 8'h00, 32'h00001234);
        post(8'h66, 8'd0, 8'hFF, 32'h0000ABCD);
        // Locked window: monitor parked
        mon_en = 1'b0;
        wr(2'd1, 32'h00000055, 4'hF);
        wr(2'd0, 32'h00FF0165, 4'hF);
        wr(2'd2, 32'd1, 4'h1);
        check("R7 valid while doorbell set", {31'd0, cmd_valid}, 32'd1);
        check("R8 kill on level 255", {31'd0, cmd_kill}, 32'd1);
        check("R6 no error yet", {31'd0, err_flag}, 32'd0);
        wr(2'd0, 32'hDEADBEEF, 4'hF);
        rd(2'd0, v); check("R4 cmd locked", v, 32'h00FF0165);
        wr(2'd1, 32'hCAFEF00D, 4'hF);
        rd(2'd1, v); check("R4 data locked", v, 32'h00000055);
        rd(2'd2, v); check("R6 error and doorbell", v, 32'd3);
        wr(2'd2, 32'd0, 4'h1);
        rd(2'd2, v); check("R3 host cannot clear doorbell", v, 32'd3);
        begin
            item_t it;
            it.op = 8'h65; it.idx = 8'h01; it.prm = 8'hFF;
            it.dat = 32'h00000055; it.kill = 1'b1;
            exp_q.push_back(it);
        end
        mon_en = 1'b1;
        for (int i = 0; i < 20 && cmd_valid; i++) @(negedge clk);
        mon_en = 1'b0;
        rd(2'd2, v); check("R6 error sticky after ack", v, 32'd2);
        // R5 stray ack has no effect
        @(negedge clk); cmd_ack = 1'b1;
        @(negedge clk); cmd_ack = 1'b0;
        rd(2'd2, v); check("R5 stray ack ignored", v, 32'd2);
        check("R5 valid stays low", {31'd0, cmd_valid}, 32'd0);
        check("R7 scoreboard empty", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule